// File: doc/BRIEF.md
# Two-Lane Five-Point Stencil Window Buffer

This block takes a raster stream of 16-bit pixels, two pixels per clock, and produces two five-point averaged pixels per clock. Each output pixel is the truncated integer mean of a centre pixel, its left and right neighbours in the same row, and the pixels directly above and below it. Rows are `ROW_W` pixels wide; the number of rows is not bounded, so the stream simply runs until the source stops.

The storage is split by pixel parity into two delay chains, one per input lane. Each chain is a short series of delay stages, and each stage tap feeds one or both of the two averaging units. Together the two chains hold about two rows of pixels. This is the same amount a single-lane line buffer needs, yet the pair of averaging units delivers twice the rate. The buffer moves as one unit: a beat is taken only when both input lanes offer data and both output lanes can accept.

Top module: `stencilReuseBuffer`

## Requirements
- R1: Beat k carries stream pixel x[2k] on the even lane and x[2k+1] on the odd lane. The two output valids are always equal, and the two input readys are always equal.
- R2: Both input readys are high exactly when both input valids and both output readys are high; a beat is taken only in such a cycle. Pixels offered in any other cycle leave the output stream unchanged.
- R3: The even output produced by beat k equals floor((x[c-1] + x[c] + x[c+1] + x[c-ROW_W] + x[c+ROW_W]) / 5) with c = 2k - ROW_W.
- R4: The odd output produced by beat k equals the same five-point mean centred on c = 2k + 1 - ROW_W.
- R5: Beats 0 to ROW_W-1 produce no output. Each beat from index ROW_W on produces exactly one output pair, valid in the cycle after the beat is taken.
- R6: While the outputs are valid and the two output readys are not both high, both output pixels and the valid stay unchanged.
- R7: When a valid output pair is consumed in a cycle with no new beat, the output valid is low in the next cycle.
- R8: The five-tap sum is formed at PIX_W+3 bits, so an all-0xFFFF input gives 0xFFFF outputs.
- R9: After synchronous reset (rst high) the output valid is low and the priming count restarts at zero.
- R10: With all valids and readys held high, one beat is taken every cycle and one output pair comes out every cycle after priming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inPixEven | input | PIX_W | Earlier pixel of the beat, x[2k] |
| inValidEven | input | 1 | Even lane offers a pixel |
| inReadyEven | output | 1 | Even lane pixel is taken this cycle |
| inPixOdd | input | PIX_W | Later pixel of the beat, x[2k+1] |
| inValidOdd | input | 1 | Odd lane offers a pixel |
| inReadyOdd | output | 1 | Odd lane pixel is taken this cycle |
| outPixEven | output | PIX_W | Averaged pixel centred on an even index |
| outValidEven | output | 1 | Even output holds a result |
| outReadyEven | input | 1 | Consumer takes the even output |
| outPixOdd | output | PIX_W | Averaged pixel centred on an odd index |
| outValidOdd | output | 1 | Odd output holds a result |
| outReadyOdd | input | 1 | Consumer takes the odd output |

## Verification
The bench builds the buffer with ROW_W = 10 and PIX_W = 16. The short row lets the ten-beat priming phase, many row wraps and the vertical taps of several rows occur within a few hundred cycles. The default width of 2000 only changes the delay-stage depths. Random valid and ready patterns exercise stalls on both sides, holding, and consumption without refill, while saturated-value and full-rate phases cover the sum width and the throughput.

// File: rtl/reuseBufPkg.sv
package reuseBufPkg;

  // Number of taps in the five-point window.
  localparam int NUM_TAPS = 5;

  // Strobes sent from the control unit to the datapath.
  typedef struct packed {
    logic shift;     // all delay stages and the output register move
    logic liveBeat;  // the beat being taken completes a full window
  } bufStrobes_t;

endpackage

// File: rtl/delayStage.sv
module delayStage #(
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);

  logic [DW-1:0] taps [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      taps[0] <= din;
      for (int i = 1; i < DEPTH; i++) begin
        taps[i] <= taps[i-1];
      end
    end
  end

  assign dout = taps[DEPTH-1];

endmodule

// File: rtl/stencilPe.sv
module stencilPe
  import reuseBufPkg::*;
#(
  parameter int PIX_W = 16
) (
  input  logic [NUM_TAPS-1:0][PIX_W-1:0] taps,
  output logic [PIX_W-1:0]               mean
);

  localparam int SUM_W = PIX_W + 3;

  logic [SUM_W-1:0] total;
  logic [SUM_W-1:0] quotient;

  always_comb begin
    total = '0;
    for (int t = 0; t < NUM_TAPS; t++) begin
      total = total + SUM_W'(taps[t]);
    end
    quotient = total / SUM_W'(NUM_TAPS);
    mean     = quotient[PIX_W-1:0];
  end

endmodule

// File: rtl/reuseBufCtrl.sv
module reuseBufCtrl
  import reuseBufPkg::*;
#(
  parameter int ROW_W = 2000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inValidEven,
  input  logic        inValidOdd,
  input  logic        outReadyEven,
  input  logic        outReadyOdd,
  output bufStrobes_t strobes,
  output logic        inReady,
  output logic        outValid
);

  localparam int CNT_W = $clog2(ROW_W + 1);

  logic [CNT_W-1:0] beatCnt;
  logic             bothReady;
  logic             takeBeat;

  assign bothReady = outReadyEven & outReadyOdd;
  assign takeBeat  = inValidEven & inValidOdd & bothReady;
  assign inReady   = takeBeat;

  assign strobes.shift    = takeBeat;
  assign strobes.liveBeat = (beatCnt == CNT_W'(ROW_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      beatCnt  <= '0;
      outValid <= 1'b0;
    end else begin
      if (takeBeat && (beatCnt != CNT_W'(ROW_W))) begin
        beatCnt <= beatCnt + 1'b1;
      end
      if (takeBeat) begin
        outValid <= strobes.liveBeat;
      end else if (bothReady) begin
        outValid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/reuseBufDatapath.sv
module reuseBufDatapath
  import reuseBufPkg::*;
#(
  parameter int ROW_W = 2000,
  parameter int PIX_W = 16
) (
  input  logic             clk,
  input  bufStrobes_t      strobes,
  input  logic [PIX_W-1:0] inPixEven,
  input  logic [PIX_W-1:0] inPixOdd,
  output logic [PIX_W-1:0] outPixEven,
  output logic [PIX_W-1:0] outPixOdd
);

  localparam int HALF = ROW_W / 2;
  localparam int LANES = 2;

  // Odd chain (newest pixel): row delay, one-beat step, row-minus-one delay.
  logic [PIX_W-1:0] oddRow1, oddRow1Step, oddRow2;
  // Even chain (older pixel): row-minus-one delay, one-beat step, row delay.
  logic [PIX_W-1:0] evenNear, evenRow1, evenRow2;

  delayStage #(.DW(PIX_W), .DEPTH(HALF)) u_oddA (
    .clk(clk), .en(strobes.shift), .din(inPixOdd), .dout(oddRow1));
  delayStage #(.DW(PIX_W), .DEPTH(1)) u_oddB (
    .clk(clk), .en(strobes.shift), .din(oddRow1), .dout(oddRow1Step));
  delayStage #(.DW(PIX_W), .DEPTH(HALF - 1)) u_oddC (
    .clk(clk), .en(strobes.shift), .din(oddRow1Step), .dout(oddRow2));

  delayStage #(.DW(PIX_W), .DEPTH(HALF - 1)) u_evenA (
    .clk(clk), .en(strobes.shift), .din(inPixEven), .dout(evenNear));
  delayStage #(.DW(PIX_W), .DEPTH(1)) u_evenB (
    .clk(clk), .en(strobes.shift), .din(evenNear), .dout(evenRow1));
  delayStage #(.DW(PIX_W), .DEPTH(HALF)) u_evenC (
    .clk(clk), .en(strobes.shift), .din(evenRow1), .dout(evenRow2));

  // Window of each lane: centre, right, left, below, above.
  logic [LANES-1:0][NUM_TAPS-1:0][PIX_W-1:0] window;
  logic [LANES-1:0][PIX_W-1:0]               peMean;
  logic [LANES-1:0][PIX_W-1:0]               resultReg;

  assign window[0] = {evenRow1, oddRow1, oddRow1Step, inPixEven, evenRow2};
  assign window[1] = {oddRow1, evenNear, evenRow1, inPixOdd, oddRow2};

  for (genvar lane = 0; lane < LANES; lane++) begin : g_pe
    stencilPe #(.PIX_W(PIX_W)) u_pe (
      .taps(window[lane]),
      .mean(peMean[lane]));

    always_ff @(posedge clk) begin
      if (strobes.shift) begin
        resultReg[lane] <= peMean[lane];
      end
    end
  end

  assign outPixEven = resultReg[0];
  assign outPixOdd  = resultReg[1];

endmodule

// File: rtl/stencilReuseBuffer.sv
module stencilReuseBuffer
  import reuseBufPkg::*;
#(
  parameter int ROW_W = 2000,
  parameter int PIX_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] inPixEven,
  input  logic             inValidEven,
  output logic             inReadyEven,
  input  logic [PIX_W-1:0] inPixOdd,
  input  logic             inValidOdd,
  output logic             inReadyOdd,
  output logic [PIX_W-1:0] outPixEven,
  output logic             outValidEven,
  input  logic             outReadyEven,
  output logic [PIX_W-1:0] outPixOdd,
  output logic             outValidOdd,
  input  logic             outReadyOdd
);

  bufStrobes_t strobes;
  logic        takeReady;
  logic        resValid;

  reuseBufCtrl #(.ROW_W(ROW_W)) u_ctrl (
    .clk(clk),
    .rst(rst),
    .inValidEven(inValidEven),
    .inValidOdd(inValidOdd),
    .outReadyEven(outReadyEven),
    .outReadyOdd(outReadyOdd),
    .strobes(strobes),
    .inReady(takeReady),
    .outValid(resValid));

  reuseBufDatapath #(.ROW_W(ROW_W), .PIX_W(PIX_W)) u_dp (
    .clk(clk),
    .strobes(strobes),
    .inPixEven(inPixEven),
    .inPixOdd(inPixOdd),
    .outPixEven(outPixEven),
    .outPixOdd(outPixOdd));

  assign inReadyEven  = takeReady;
  assign inReadyOdd   = takeReady;
  assign outValidEven = resValid;
  assign outValidOdd  = resValid;

endmodule

// File: rtl/reuseBufChecker.sv
module reuseBufChecker #(
  parameter int ROW_W = 2000,
  parameter int PIX_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             inValidEven,
  input logic             inReadyEven,
  input logic             inValidOdd,
  input logic             inReadyOdd,
  input logic [PIX_W-1:0] outPixEven,
  input logic             outValidEven,
  input logic             outReadyEven,
  input logic [PIX_W-1:0] outPixOdd,
  input logic             outValidOdd,
  input logic             outReadyOdd
);

  localparam int CNT_W = $clog2(ROW_W + 1);

  logic [CNT_W-1:0] seenBeats;

  always_ff @(posedge clk) begin
    if (rst) begin
      seenBeats <= '0;
    end else if (inReadyEven && seenBeats != CNT_W'(ROW_W)) begin
      seenBeats <= seenBeats + 1'b1;
    end
  end

  // R1: lanes move together
  a_r1_lanes_paired: assert property (@(posedge clk) disable iff (rst)
    (outValidEven == outValidOdd) && (inReadyEven == inReadyOdd));

  // R2: a beat is taken only with every party willing
  a_r2_take_rule: assert property (@(posedge clk) disable iff (rst)
    inReadyEven |-> (inValidEven && inValidOdd && outReadyEven && outReadyOdd));

  // R5: nothing comes out before the window fills
  a_r5_priming: assert property (@(posedge clk) disable iff (rst)
    (seenBeats < CNT_W'(ROW_W)) |-> !outValidEven);

  // R6: stalled output is held
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (outValidEven && !(outReadyEven && outReadyOdd)) |=>
      (outValidEven && $stable(outPixEven) && $stable(outPixOdd)));

  // R7: consumed output without refill empties
  a_r7_drain: assert property (@(posedge clk) disable iff (rst)
    (outValidEven && outReadyEven && outReadyOdd && !inReadyEven) |=> !outValidEven);

  // R9: reset clears the output
  a_r9_reset: assert property (@(posedge clk)
    rst |=> !outValidEven);

endmodule

bind stencilReuseBuffer reuseBufChecker #(.ROW_W(ROW_W), .PIX_W(PIX_W)) u_chk (
  .clk(clk),
  .rst(rst),
  .inValidEven(inValidEven),
  .inReadyEven(inReadyEven),
  .inValidOdd(inValidOdd),
  .inReadyOdd(inReadyOdd),
  .outPixEven(outPixEven),
  .outValidEven(outValidEven),
  .outReadyEven(outReadyEven),
  .outPixOdd(outPixOdd),
  .outValidOdd(outValidOdd),
  .outReadyOdd(outReadyOdd));

// File: tb/tb_stencilReuseBuffer.sv
`timescale 1ns/1ps
module tb_stencilReuseBuffer;

  localparam int ROW_W = 10;
  localparam int PIX_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [PIX_W-1:0] inPixEven = '0, inPixOdd = '0;
  logic             inValidEven = 1'b0, inValidOdd = 1'b0;
  logic             outReadyEven = 1'b0, outReadyOdd = 1'b0;
  logic             inReadyEven, inReadyOdd;
  logic [PIX_W-1:0] outPixEven, outPixOdd;
  logic             outValidEven, outValidOdd;

  stencilReuseBuffer #(.ROW_W(ROW_W), .PIX_W(PIX_W)) dut (
    .clk(clk), .rst(rst),
    .inPixEven(inPixEven), .inValidEven(inValidEven), .inReadyEven(inReadyEven),
    .inPixOdd(inPixOdd), .inValidOdd(inValidOdd), .inReadyOdd(inReadyOdd),
    .outPixEven(outPixEven), .outValidEven(outValidEven), .outReadyEven(outReadyEven),
    .outPixOdd(outPixOdd), .outValidOdd(outValidOdd), .outReadyOdd(outReadyOdd));

  always #2 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int pix[$];
  bit expValid = 0;
  int expEven = 0, expOdd = 0;
  bit holding = 0;
  int prevEven = 0, prevOdd = 0;
  int fullRateBeats = 0;
  int fullRateOuts = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int meanAt(input int c);
    return (pix[c-1] + pix[c] + pix[c+1] + pix[c-ROW_W] + pix[c+ROW_W]) / 5;
  endfunction

  // Compare the outputs produced by the previous edge with the model.
  task automatic compareOutputs();
    check(outValidEven == outValidOdd, "R1", int'(outValidOdd), int'(outValidEven));
    check(outValidEven == expValid, holding ? "R6" : "R5", int'(outValidEven), int'(expValid));
    if (expValid && outValidEven) begin
      if (holding) begin
        check(outPixEven == prevEven && outPixOdd == prevOdd, "R6", int'(outPixEven), prevEven);
      end
      check(int'(outPixEven) == expEven, "R3", int'(outPixEven), expEven);
      check(int'(outPixOdd) == expOdd, "R4", int'(outPixOdd), expOdd);
    end
  endtask

  // One cycle: compare, drive, check ready, advance the model.
  task automatic cycle(input int pValid, input int pReady, input int mode, input bit fullRate);
    bit fire;
    bit bothRdy;
    @(negedge clk);
    compareOutputs();
    inValidEven  = ($urandom_range(99) < pValid);
    inValidOdd   = ($urandom_range(99) < pValid);
    outReadyEven = ($urandom_range(99) < pReady);
    outReadyOdd  = (pReady >= 100) ? 1'b1 :
                   ($urandom_range(99) < 50) ? outReadyEven : ($urandom_range(99) < pReady);
    case (mode)
      1: begin inPixEven = '1; inPixOdd = '1; end
      2: begin inPixEven = PIX_W'(pix.size()); inPixOdd = PIX_W'(pix.size() + 1); end
      default: begin inPixEven = PIX_W'($urandom); inPixOdd = PIX_W'($urandom); end
    endcase
    #0.5;
    bothRdy = outReadyEven && outReadyOdd;
    fire = inValidEven && inValidOdd && bothRdy;
    check(inReadyEven == fire, "R2", int'(inReadyEven), int'(fire));
    check(inReadyOdd == inReadyEven, "R1", int'(inReadyOdd), int'(inReadyEven));
    holding = expValid && !bothRdy;
    prevEven = int'(outPixEven);
    prevOdd  = int'(outPixOdd);
    if (fire) begin
      int k;
      k = pix.size() / 2;
      pix.push_back(int'(inPixEven));
      pix.push_back(int'(inPixOdd));
      if (fullRate) fullRateBeats++;
      if (k >= ROW_W) begin
        expValid = 1;
        expEven = meanAt(2 * k - ROW_W);
        expOdd  = meanAt(2 * k + 1 - ROW_W);
        if (fullRate) fullRateOuts++;
      end else begin
        expValid = 0;
      end
    end else if (bothRdy) begin
      if (expValid) check(1'b1, "R7", 0, 0);
      expValid = 0;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    inValidEven = 0; inValidOdd = 0; outReadyEven = 0; outReadyOdd = 0;
    repeat (3) @(negedge clk);
    check(outValidEven == 1'b0 && outValidOdd == 1'b0, "R9", int'(outValidEven), 0);
    rst = 1'b0;
    pix.delete();
    expValid = 0;
    holding = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    doReset();
    // R10: full rate, ramp data
    for (int i = 0; i < 60; i++) cycle(100, 100, 2, 1'b1);
    check(fullRateBeats == 60, "R10", fullRateBeats, 60);
    check(fullRateOuts == 60 - ROW_W, "R10", fullRateOuts, 60 - ROW_W);
    // R2 R6 R7: random stalls, random data
    for (int i = 0; i < 1500; i++) cycle(80, 70, 0, 1'b0);
    // R8: saturated pixels
    doReset();
    for (int i = 0; i < 80; i++) cycle(90, 90, 1, 1'b0);
    check(pix.size() > 2 * (ROW_W + 2), "R8", pix.size(), 2 * (ROW_W + 2));
    // R9: reset mid-stream then R5 priming restarts
    doReset();
    for (int i = 0; i < 800; i++) cycle(60, 60, 0, 1'b0);
    @(negedge clk);
    compareOutputs();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule